// File: doc/BRIEF.md
# Posted Command-Word Register Bridge

This block sits between a host register port and the small 8-bit register bank of a two-wire serial controller. The host never reaches the bank directly. It writes one 64-bit command word that holds an operation code, a direction flag, a 3-bit register index, the write data and a launch flag in the top bit. When the launch flag is set and the operation selects the controller registers, the bridge performs one access on the bank. It folds any read result into the low field of the word and then drops the launch flag. The host polls the word through the read strobe until the flag reads back as zero.

The bank port is a plain single-cycle strobe interface, not a stream. Exactly one cycle after the word is captured, the bridge asserts either a write strobe or a read strobe for one cycle. The bank must present read data combinationally during that cycle. The access finishes on the second clock edge after capture. On that edge the launch flag clears and, for a read, the data field takes the register value. While an access is in flight, any new host write is dropped and a sticky error flag is set. Index 3 is an alias: a write to it reaches the clock-control register, and a read from it reaches the status register. The bridge therefore exposes a 4-bit bank address, in which status is address 8.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the stored command word, `host_rdata` and `err_sticky` are all zero, and neither bank strobe is active.
- R2: A pulse on `host_rd` loads `host_rdata` with the stored command word on that clock edge. While `host_rd` is low, `host_rdata` holds its value, including across host writes.
- R3: A word is captured from `host_wdata` on a clock edge where `host_wr` is high and no access is in flight. If that word has bit 63 set and the operation field [60:57] equals 6, exactly one bank strobe pulses for the single cycle that follows the capture. That strobe is `bank_re` if bit 56 is 1 and `bank_we` if bit 56 is 0. On a write, `bank_wdata` carries word bits [7:0].
- R4: `bank_addr` equals the index field [34:32] for every write and for reads of indexes other than 3. A read of index 3 uses `bank_addr` = 8 (status), while a write to index 3 uses address 3 (clock control).
- R5: A read access completes on the second clock edge after capture. On that edge bit 63 clears and the data field [31:0] becomes the bank value, zero-extended. Bits [62:32] keep the values the host wrote.
- R6: A write access also completes on the second clock edge after capture. On that edge only bit 63 changes, to zero, and every other bit of the word keeps its written value.
- R7: A captured word with bit 63 set and an operation field other than 6 completes at once. The stored word is the written word with bit 63 and the data field [31:0] forced to zero, and no bank strobe occurs.
- R8: A captured word with bit 63 clear is stored unchanged, and no bank strobe occurs.
- R9: A host write that arrives while an access is in flight is dropped and leaves the stored word and the access unchanged. It also sets `err_sticky`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rd | input | 1 | Host read strobe; loads host_rdata |
| host_rdata | output | 64 | Command word as last read |
| err_sticky | output | 1 | Set by a write dropped while busy; cleared only by reset |
| bank_we | output | 1 | One-cycle bank write strobe |
| bank_re | output | 1 | One-cycle bank read strobe |
| bank_addr | output | 4 | Bank register address (0-7 from index, 8 = status) |
| bank_wdata | output | 8 | Bank write data |
| bank_rdata | input | 8 | Bank read data, valid during the bank_re cycle |

## Verification
The assertions assume two things about the inputs. The bank drives `bank_rdata` combinationally from `bank_addr` during the strobe cycle, and the host strobes are sampled only on clock edges outside reset. The bench bank model reads combinationally and writes on the strobe edge. All host stimulus changes on the falling edge, so every strobe is seen on exactly one rising edge. The sweep covers every index in both directions, so the status alias at index 3 and the overlap case that sets the error flag are both exercised inside these limits.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WORD_W    = 64;
  localparam int DATA_W    = 32;
  localparam int VALID_BIT = 63;
  localparam int OP_LO     = 57;
  localparam int OP_W      = 4;
  localparam int RD_BIT    = 56;
  localparam int IDX_LO    = 32;
  localparam int IDX_W     = 3;
  localparam int BANK_AW   = 4;

  localparam logic [OP_W-1:0]    OP_INTERNAL = 4'd6;
  localparam logic [IDX_W-1:0]   ALIAS_IDX   = 3'd3;
  localparam logic [BANK_AW-1:0] ADDR_STATUS = 4'd8;

  function automatic logic is_internal_op(input logic [OP_W-1:0] op);
    return op == OP_INTERNAL;
  endfunction
endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
  import ibr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               rd_flag,
  input  logic [IDX_W-1:0]   idx,
  input  logic [REG_W-1:0]   data_lo,
  output logic               is_rd,
  output logic [BANK_AW-1:0] addr,
  output logic [REG_W-1:0]   wdata
);
  // Index 3 is the one index whose target depends on direction.
  always_comb begin
    is_rd = rd_flag;
    wdata = data_lo;
    if (rd_flag && idx == ALIAS_IDX) addr = ADDR_STATUS;
    else                             addr = BANK_AW'(idx);
  end
endmodule

// File: rtl/ibr_access_seq.sv
module ibr_access_seq #(
  parameter int ACC_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic strobe,
  output logic done
);
  localparam int CW = $clog2(ACC_LAT + 1);

  logic [CW-1:0] cnt;

  assign strobe = busy && (cnt == '0);
  assign done   = busy && (cnt == CW'(ACC_LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  // R5 R6: the counter never runs past the completion count
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CW'(ACC_LAT - 1)));
  // R6: completion ends the access on the next edge
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> !busy);
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int ACC_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic               host_rd,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               err_sticky,
  output logic               bank_we,
  output logic               bank_re,
  output logic [BANK_AW-1:0] bank_addr,
  output logic [REG_W-1:0]   bank_wdata,
  input  logic [REG_W-1:0]   bank_rdata
);
  logic [WORD_W-1:0] cmd_q;
  logic [REG_W-1:0]  rd_hold;
  logic busy, strobe, done, is_rd;
  logic accept, in_valid, in_int, launch;

  assign accept   = host_wr && !busy;
  assign in_valid = host_wdata[VALID_BIT];
  assign in_int   = is_internal_op(host_wdata[OP_LO +: OP_W]);
  assign launch   = accept && in_valid && in_int;

  ibr_access_seq #(.ACC_LAT(ACC_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .busy(busy), .strobe(strobe), .done(done)
  );

  ibr_cmd_decode #(.REG_W(REG_W)) u_dec (
    .rd_flag(cmd_q[RD_BIT]),
    .idx(cmd_q[IDX_LO +: IDX_W]),
    .data_lo(cmd_q[REG_W-1:0]),
    .is_rd(is_rd),
    .addr(bank_addr),
    .wdata(bank_wdata)
  );

  assign bank_we = strobe && !is_rd;
  assign bank_re = strobe && is_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rd_hold <= '0;
    end else begin
      if (bank_re) rd_hold <= bank_rdata;
      if (accept) begin
        if (in_valid && !in_int)
          cmd_q <= {1'b0, host_wdata[WORD_W-2:DATA_W], {DATA_W{1'b0}}};
        else
          cmd_q <= host_wdata;
      end else if (done) begin
        cmd_q[VALID_BIT] <= 1'b0;
        if (is_rd) cmd_q[DATA_W-1:0] <= DATA_W'(rd_hold);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr && busy) err_sticky <= 1'b1;
      if (host_rd) host_rdata <= cmd_q;
    end
  end

  // R3: never both strobes at once
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_we && bank_re));
  // R3: a strobe only ever belongs to a launched word
  assert_strobe_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we || bank_re) |-> cmd_q[VALID_BIT]);
  // R5 R6: completion drops the launch flag
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd_q[VALID_BIT]);
  // R7: other operations finish at once with zero data
  assert_other_op_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !busy && host_wdata[VALID_BIT] && host_wdata[OP_LO +: OP_W] != OP_INTERNAL)
    |=> (!cmd_q[VALID_BIT] && cmd_q[DATA_W-1:0] == '0 && !bank_we && !bank_re));
  // R9: a write during an access raises the flag and leaves the word alone
  assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && busy && !done) |=> (err_sticky && $stable(cmd_q)));
  // R9: the flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: tb/ibr_bridge_bench.sv
`timescale 1ns/1ps
module ibr_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [63:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [63:0] host_rdata;
  logic        err_sticky, bank_we, bank_re;
  logic [3:0]  bank_addr;
  logic [7:0]  bank_wdata, bank_rdata;
  logic [7:0]  mem [0:8];
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ibr_bridge u_ibr_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .err_sticky(err_sticky),
    .bank_we(bank_we), .bank_re(bank_re), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  // register bank model: combinational read, write on strobe edge
  assign bank_rdata = (bank_addr <= 4'd8) ? mem[bank_addr] : 8'h00;
  always @(posedge clk) if (bank_we && bank_addr <= 4'd8) mem[bank_addr] <= bank_wdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit v, logic [3:0] op, bit rd, logic [2:0] idx, logic [31:0] d);
    return {v, 2'b10, op, rd, 21'h0B5A3, idx, d};
  endfunction

  function automatic logic [7:0] wval(int i);
    return 8'(i * 37 + 8'h1C);
  endfunction

  // launch an internal access and follow it to completion
  task automatic access(input logic [63:0] w, input bit rd, input logic [3:0] eaddr,
                        input logic [63:0] efinal, input string req);
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wr = 0;
    chk(bank_we == !rd && bank_re == rd, "R3 strobe kind", {62'd0, bank_we, bank_re}, {62'd0, !rd, rd});
    chk(bank_addr == eaddr, "R4 bank address", 64'(bank_addr), 64'(eaddr));
    if (!rd) chk(bank_wdata == w[7:0], "R3 write data", 64'(bank_wdata), 64'(w[7:0]));
    host_rd = 1;
    @(negedge clk);
    chk(!bank_we && !bank_re, "R3 single strobe", {62'd0, bank_we, bank_re}, 64'd0);
    chk(host_rdata == w, {req, " in flight"}, host_rdata, w);
    @(negedge clk);
    chk(host_rdata[63] == 1'b1, {req, " valid before edge 2"}, host_rdata, w);
    @(negedge clk); host_rd = 0;
    chk(host_rdata == efinal, {req, " completion"}, host_rdata, efinal);
  endtask

  task automatic hread(output logic [63:0] v);
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
    v = host_rdata;
  endtask

  initial begin
    logic [63:0] w, e, v, prev;
    for (int i = 0; i < 9; i++) mem[i] = 8'h00;
    mem[8] = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(host_rdata == 0 && !err_sticky && !bank_we && !bank_re, "R1 reset outputs",
        {host_rdata[62:0], err_sticky}, 64'd0);
    hread(v);
    chk(v == 0, "R1 reset word", v, 64'd0);

    // write sweep over every index (R3, R4, R6)
    for (int i = 0; i < 8; i++) begin
      w = mk(1, 4'd6, 0, 3'(i), {24'hABCDEF, wval(i)});
      e = w; e[63] = 0;
      access(w, 0, 4'(i), e, "R6 write");
    end
    chk(mem[3] == wval(3), "R4 index 3 write reaches clock control", 64'(mem[3]), 64'(wval(3)));
    chk(mem[8] == 8'hA5, "R4 status untouched by write", 64'(mem[8]), 64'hA5);

    // read sweep (R4, R5)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ev;
      ev = (i == 3) ? 8'hA5 : wval(i);
      w = mk(1, 4'd6, 1, 3'(i), 32'hFFFF_FFFF);
      e = w; e[63] = 0; e[31:0] = {24'd0, ev};
      access(w, 1, (i == 3) ? 4'd8 : 4'(i), e, "R5 read");
    end

    // R7 other operation codes
    for (int op = 0; op < 16; op++) begin
      if (op == 6) continue;
      w = mk(1, 4'(op), op[0], 3'(op % 8), 32'h1234_5678);
      e = w; e[63] = 0; e[31:0] = 0;
      @(negedge clk); host_wr = 1; host_wdata = w;
      @(negedge clk); host_wr = 0; host_rd = 1;
      chk(!bank_we && !bank_re, "R7 no strobe", {62'd0, bank_we, bank_re}, 64'd0);
      @(negedge clk); host_rd = 0;
      chk(host_rdata == e, "R7 immediate zero", host_rdata, e);
    end

    // R8 valid clear, plus R2 hold while host_rd low
    prev = host_rdata;
    w = mk(0, 4'd6, 0, 3'd1, 32'h0000_0077);
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wr = 0;
    chk(!bank_we && !bank_re, "R8 no strobe", {62'd0, bank_we, bank_re}, 64'd0);
    @(negedge clk);
    chk(host_rdata == prev, "R2 hold without read", host_rdata, prev);
    hread(v);
    chk(v == w, "R8 stored unchanged", v, w);
    chk(mem[1] == wval(1), "R8 bank untouched", 64'(mem[1]), 64'(wval(1)));

    // R9 write while busy
    chk(!err_sticky, "R9 flag clear before overlap", 64'(err_sticky), 64'd0);
    w = mk(1, 4'd6, 1, 3'd2, 32'h0);
    e = w; e[63] = 0; e[31:0] = {24'd0, wval(2)};
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wdata = mk(1, 4'd6, 0, 3'd5, 32'h0000_00EE);
    @(negedge clk); host_wr = 0;
    chk(err_sticky, "R9 flag raised", 64'(err_sticky), 64'd1);
    repeat (3) @(negedge clk);
    hread(v);
    chk(v == e, "R9 first access intact", v, e);
    chk(mem[5] == wval(5), "R9 dropped write not applied", 64'(mem[5]), 64'(wval(5)));
    w = mk(0, 4'd1, 0, 3'd0, 32'h0);
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wr = 0;
    chk(err_sticky, "R9 flag sticky", 64'(err_sticky), 64'd1);

    // R1 reset clears the flag
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!err_sticky && host_rdata == 0, "R1 reset clears", {host_rdata[62:0], err_sticky}, 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule